// File: doc/BRIEF.md
# Memory bank select controller

This block lets a processor with a small external memory and a single chip-enable reach several switchable banks of storage. A front-panel button steps a bank position counter through the four banks of an added memory and then the one bank of the original memory, and then back to the start. Address, data and write-enable wiring is shared by both memories. Only the processor's chip-enable is steered, to one memory or the other.

The counter's low bits drive the upper address lines of the added memory. The current position is shown as a digit on a seven-segment display. An active-low power-on-reset input holds both memory enables inactive until the system has settled, so nothing is selected or written while power comes up. The button is synchronized to the system clock and edge-detected, so one press gives exactly one step.

Top module: `bank_sel_ctrl`

## Requirements
- R1: While `rst` is high at a clock edge, the position returns to 0. After reset, `bank_addr` is 0 and `seg` shows the digit 0.
- R2: Each press of `btn` advances the position by exactly one, however long the button is held. A press is a low-to-high change of `btn` held for at least three clock cycles.
- R3: The position goes 0, 1, 2, 3, 4 and then back to 0.
- R4: At positions 0 to 3, with `por_n` high, `ext_ce_n` equals `cpu_ce_n` and `orig_ce_n` is held high.
- R5: At position 4, with `por_n` high, `orig_ce_n` equals `cpu_ce_n` and `ext_ce_n` is held high.
- R6: `bank_addr` equals the position modulo 4. This gives 0 to 3 at the added-memory positions and 0 at position 4.
- R7: While `por_n` is low, `ext_ce_n` and `orig_ce_n` are both high, whatever the value of `cpu_ce_n`.
- R8: `seg` shows the position as an active-high digit, with bit 0 = segment a through bit 6 = segment g. The codes are 0 = 7'h3F, 1 = 7'h06, 2 = 7'h5B, 3 = 7'h4F and 4 = 7'h66. Any other value blanks the display.
- R9: `por_n` has no effect on the position counter. Presses made while `por_n` is low still advance it.
- R10: Both enables are never low at the same time. When `cpu_ce_n` is low and `por_n` is high, exactly one of them is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| por_n | input | 1 | Power-on-reset, low blocks both memory enables |
| btn | input | 1 | Raw bank-step button, high while pressed |
| cpu_ce_n | input | 1 | Processor chip-enable, active low |
| ext_ce_n | output | 1 | Chip-enable of the added memory, active low |
| orig_ce_n | output | 1 | Chip-enable of the original memory, active low |
| bank_addr | output | 2 | Upper address lines of the added memory |
| seg | output | 7 | Seven-segment digit, bit 0 = a through bit 6 = g |

## Verification
The bench builds the block with its default values: four added banks and a two-stage button synchronizer. With these values the position is a 3-bit counter and the power-of-two variant is used, in which the top count bit steers the enable. A full lap of five presses therefore reaches the wrap from 4 to 0 and every display code. Each position is checked with the processor enable both high and low, so that the steering and the inactive level of the other enable are both seen. Long button holds, presses made during power-on-reset and a reset in the middle of a lap are also covered.

// File: rtl/bank_sel_pkg.sv
`timescale 1ns/1ps
package bank_sel_pkg;

    localparam int SEG_W = 7;

    // Active-high segments, bit 0 = a ... bit 6 = g
    function automatic logic [SEG_W-1:0] digit_to_seg(input int unsigned digit);
        logic [SEG_W-1:0] pattern;
        case (digit)
            0:       pattern = 7'h3F;
            1:       pattern = 7'h06;
            2:       pattern = 7'h5B;
            3:       pattern = 7'h4F;
            4:       pattern = 7'h66;
            5:       pattern = 7'h6D;
            6:       pattern = 7'h7D;
            7:       pattern = 7'h07;
            8:       pattern = 7'h7F;
            9:       pattern = 7'h6F;
            default: pattern = '0;
        endcase
        return pattern;
    endfunction

endpackage

// File: rtl/bank_btn_edge.sv
`timescale 1ns/1ps
module bank_btn_edge #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic btn_raw,
    output logic step
);

    typedef struct packed {
        logic [SYNC_STAGES-1:0] sync;
        logic                   prev;
    } edge_state_t;

    edge_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        st_d.sync = {st_q.sync[SYNC_STAGES-2:0], btn_raw};
        st_d.prev = st_q.sync[SYNC_STAGES-1];
        if (rst) begin
            st_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    // Rising edge of the synchronized button
    assign step = st_q.sync[SYNC_STAGES-1] & ~st_q.prev;

endmodule

// File: rtl/bank_step_counter.sv
`timescale 1ns/1ps
module bank_step_counter #(
    parameter int NUM_ADDED = 4,
    localparam int LAST  = NUM_ADDED,
    localparam int CNT_W = $clog2(NUM_ADDED + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             step,
    output logic [CNT_W-1:0] pos,
    output logic             sel_orig
);

    typedef struct packed {
        logic [CNT_W-1:0] pos;
    } cnt_state_t;

    cnt_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (step) begin
            if (st_q.pos == CNT_W'(LAST)) begin
                st_d.pos = '0;
            end else begin
                st_d.pos = st_q.pos + CNT_W'(1);
            end
        end
        if (rst) begin
            st_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign pos = st_q.pos;

    // A power-of-two bank count lets the top count bit steer the enable.
    generate
        if ((NUM_ADDED & (NUM_ADDED - 1)) == 0) begin : g_top_bit
            assign sel_orig = st_q.pos[CNT_W-1];
        end else begin : g_compare
            assign sel_orig = (st_q.pos == CNT_W'(LAST));
        end
    endgenerate

endmodule

// File: rtl/bank_ce_router.sv
`timescale 1ns/1ps
module bank_ce_router (
    input  logic por_n,
    input  logic sel_orig,
    input  logic cpu_ce_n,
    output logic ext_ce_n,
    output logic orig_ce_n
);

    logic access;

    always_comb begin
        access    = por_n & ~cpu_ce_n;
        ext_ce_n  = ~(access & ~sel_orig);
        orig_ce_n = ~(access &  sel_orig);
    end

endmodule

// File: rtl/bank_seg_decoder.sv
`timescale 1ns/1ps
module bank_seg_decoder
    import bank_sel_pkg::*;
#(
    parameter int CNT_W = 3
) (
    input  logic [CNT_W-1:0] pos,
    output logic [SEG_W-1:0] seg
);

    always_comb begin
        seg = digit_to_seg(int'(pos));
    end

endmodule

// File: rtl/bank_sel_ctrl.sv
`timescale 1ns/1ps
module bank_sel_ctrl
    import bank_sel_pkg::*;
#(
    parameter int NUM_ADDED   = 4,
    parameter int SYNC_STAGES = 2,
    localparam int CNT_W  = $clog2(NUM_ADDED + 1),
    localparam int ADDR_W = $clog2(NUM_ADDED)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              por_n,
    input  logic              btn,
    input  logic              cpu_ce_n,
    output logic              ext_ce_n,
    output logic              orig_ce_n,
    output logic [ADDR_W-1:0] bank_addr,
    output logic [SEG_W-1:0]  seg
);

    logic             step;
    logic [CNT_W-1:0] bank_q;
    logic             sel_orig;

    bank_btn_edge #(.SYNC_STAGES(SYNC_STAGES)) u_btn (
        .clk     (clk),
        .rst     (rst),
        .btn_raw (btn),
        .step    (step)
    );

    bank_step_counter #(.NUM_ADDED(NUM_ADDED)) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .step     (step),
        .pos      (bank_q),
        .sel_orig (sel_orig)
    );

    bank_ce_router u_route (
        .por_n     (por_n),
        .sel_orig  (sel_orig),
        .cpu_ce_n  (cpu_ce_n),
        .ext_ce_n  (ext_ce_n),
        .orig_ce_n (orig_ce_n)
    );

    bank_seg_decoder #(.CNT_W(CNT_W)) u_seg (
        .pos (bank_q),
        .seg (seg)
    );

    assign bank_addr = bank_q[ADDR_W-1:0];

endmodule

// File: rtl/bank_sel_chk.sv
`timescale 1ns/1ps
module bank_sel_chk #(
    parameter int NUM_ADDED = 4,
    localparam int CNT_W  = $clog2(NUM_ADDED + 1),
    localparam int ADDR_W = $clog2(NUM_ADDED)
) (
    input logic              clk,
    input logic              rst,
    input logic              por_n,
    input logic              cpu_ce_n,
    input logic              ext_ce_n,
    input logic              orig_ce_n,
    input logic [ADDR_W-1:0] bank_addr,
    input logic [6:0]        seg,
    input logic [CNT_W-1:0]  bank_q
);

    logic valid_q;

    always_ff @(posedge clk) begin
        valid_q <= ~rst;
    end

    // R3: the position only steps by one or wraps from the last position to 0
    a_r3_step_or_wrap: assert property (@(posedge clk) disable iff (rst)
        (valid_q && bank_q != $past(bank_q)) |->
        ((bank_q == CNT_W'($past(bank_q) + 1)) ||
         ($past(bank_q) == CNT_W'(NUM_ADDED) && bank_q == '0)));

    // R7: power-on-reset blocks both enables
    a_r7_por_blocks: assert property (@(posedge clk) disable iff (rst)
        !por_n |-> (ext_ce_n && orig_ce_n));

    // R10: never both enables active
    a_r10_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(ext_ce_n == 1'b0 && orig_ce_n == 1'b0));

    // R10: an access with power good selects exactly one memory
    a_r10_one_selected: assert property (@(posedge clk) disable iff (rst)
        (por_n && !cpu_ce_n) |-> ($countones({ext_ce_n, orig_ce_n}) == 1));

    // R8: a valid position never blanks the display
    a_r8_never_blank: assert property (@(posedge clk) disable iff (rst)
        valid_q |-> (seg != 7'h00));

    // R6: the added-memory address follows the position
    a_r6_addr_follows: assert property (@(posedge clk) disable iff (rst)
        valid_q |-> (bank_addr == bank_q[ADDR_W-1:0]));

endmodule

bind bank_sel_ctrl bank_sel_chk #(.NUM_ADDED(NUM_ADDED)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .por_n     (por_n),
    .cpu_ce_n  (cpu_ce_n),
    .ext_ce_n  (ext_ce_n),
    .orig_ce_n (orig_ce_n),
    .bank_addr (bank_addr),
    .seg       (seg),
    .bank_q    (bank_q)
);

// File: tb/test_bank_sel_ctrl.sv
`timescale 1ns/1ps
module test_bank_sel_ctrl;

    logic       clk = 1'b0;
    logic       rst;
    logic       por_n;
    logic       btn;
    logic       cpu_ce_n;
    logic       ext_ce_n;
    logic       orig_ce_n;
    logic [1:0] bank_addr;
    logic [6:0] seg;

    int n_checks = 0;
    int n_fail   = 0;
    int exp_pos  = 0;

    always #10 clk = ~clk;   // 50 MHz

    bank_sel_ctrl i_bank_sel_ctrl (
        .clk       (clk),
        .rst       (rst),
        .por_n     (por_n),
        .btn       (btn),
        .cpu_ce_n  (cpu_ce_n),
        .ext_ce_n  (ext_ce_n),
        .orig_ce_n (orig_ce_n),
        .bank_addr (bank_addr),
        .seg       (seg)
    );

    function automatic logic [6:0] exp_seg(input int p);
        case (p)
            0: return 7'h3F;
            1: return 7'h06;
            2: return 7'h5B;
            3: return 7'h4F;
            4: return 7'h66;
            default: return 7'h00;
        endcase
    endfunction

    task automatic check(input string req, input string what,
                         input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Checks the enables for both processor enable levels, then address and display
    task automatic check_pos(input string tag);
        for (int lvl = 0; lvl < 2; lvl++) begin
            logic e_ext, e_orig;
            cpu_ce_n = lvl[0];
            #2;
            e_ext  = !(por_n && !cpu_ce_n && exp_pos != 4);
            e_orig = !(por_n && !cpu_ce_n && exp_pos == 4);
            if (!por_n) begin
                check("R7", {tag, " ext_ce_n"},  {7'd0, ext_ce_n},  8'd1);
                check("R7", {tag, " orig_ce_n"}, {7'd0, orig_ce_n}, 8'd1);
            end else if (exp_pos == 4) begin
                check("R5", {tag, " ext_ce_n"},  {7'd0, ext_ce_n},  {7'd0, e_ext});
                check("R5", {tag, " orig_ce_n"}, {7'd0, orig_ce_n}, {7'd0, e_orig});
            end else begin
                check("R4", {tag, " ext_ce_n"},  {7'd0, ext_ce_n},  {7'd0, e_ext});
                check("R4", {tag, " orig_ce_n"}, {7'd0, orig_ce_n}, {7'd0, e_orig});
            end
        end
        cpu_ce_n = 1'b1;
        check("R6", {tag, " bank_addr"}, {6'd0, bank_addr}, 8'(exp_pos % 4));
        check("R8", {tag, " seg"}, {1'b0, seg}, {1'b0, exp_seg(exp_pos)});
    endtask

    task automatic press(input int hold);
        @(negedge clk);
        btn = 1'b1;
        repeat (hold) @(negedge clk);
        btn = 1'b0;
        repeat (6) @(negedge clk);
        exp_pos = (exp_pos == 4) ? 0 : exp_pos + 1;
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        exp_pos = 0;
        @(negedge clk);
        check("R1", "reset bank_addr", {6'd0, bank_addr}, 8'd0);
        check("R1", "reset seg", {1'b0, seg}, 8'h3F);
        check_pos("R1 after reset");
    endtask

    task automatic t_walk();
        // R3: a full lap through all five positions and the wrap
        for (int i = 0; i < 6; i++) begin
            press(4);
            check_pos($sformatf("R3 lap step %0d", i));
        end
    endtask

    task automatic t_hold();
        // R2: a long hold counts once
        press(40);
        check("R2", "long hold advances by one", {1'b0, seg}, {1'b0, exp_seg(exp_pos)});
        check_pos("R2 after hold");
        press(3);
        check("R2", "minimum press advances by one", {1'b0, seg}, {1'b0, exp_seg(exp_pos)});
    endtask

    task automatic t_por();
        // R7 and R9: enables blocked, but presses still count
        @(negedge clk);
        por_n = 1'b0;
        check_pos("R7 por low");
        press(4);
        check("R9", "press during por advances", {1'b0, seg}, {1'b0, exp_seg(exp_pos)});
        check_pos("R7 por low after press");
        while (exp_pos != 4) press(4);
        check_pos("R7 por low at original bank");
        por_n = 1'b1;
        check_pos("R9 por released");
    endtask

    task automatic t_sync_reset();
        // R1: reset in the middle of a lap
        press(4);
        press(4);
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        exp_pos = 0;
        check("R1", "mid-lap reset seg", {1'b0, seg}, 8'h3F);
        check_pos("R1 mid-lap");
        press(4);
        check_pos("R2 after mid-lap reset");
    endtask

    initial begin
        rst      = 1'b1;
        por_n    = 1'b1;
        btn      = 1'b0;
        cpu_ce_n = 1'b1;
        t_reset();
        t_walk();
        t_hold();
        t_por();
        t_sync_reset();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule